// File: doc/BRIEF.md
# Paged EEPROM Controller with Row Writes

The controller puts one 64-byte page of non-volatile storage into the data space of an 8-bit processor. The page sits at window addresses 00h to 3Fh. An external bank-select input picks which page appears in the window, and the page count is set by the `NUM_BANKS` parameter (1 or 2). Reads are combinational and return data in the same cycle as an ordinary RAM read. There is no staging buffer, so each write goes straight to its target address.

Programming is timed. A write that is accepted makes the block busy for `PROG_CYCLES` clocks, and the array cell changes when the busy period ends. A single control/status register sets the following:
- whether the array is switched off;
- whether programming is allowed;
- whether writes program one byte at a time or gather up to eight bytes of one aligned row and program them together.

While the block is busy, the register shows only the busy flag and ignores writes to it. A stop request disables the array at once, with the same effect as the off bit.

Top module: `nvm_page_ctrl`

## Requirements
- R1: After reset the control register reads 40h (array off, nothing else set) and `prog_done` is low. Every array cell holds FFh, which is visible once the array is switched on.
- R2: The window is blocked when any of these holds: the off bit (bit6) is set, `bank_valid` is low, or `bank_idx` is not below `NUM_BANKS`. A blocked window reads 00h and ignores writes.
- R3: When the window is accessible and the block is not busy, `win_rdata` shows the addressed cell in the same cycle that `win_rd` is high.
- R4: When the programming-enable bit (bit0) is clear, window writes change no cell and do not make the block busy.
- R5: In byte mode (bit0=1, bit1=0), an accepted window write makes the block busy from the next cycle for exactly `PROG_CYCLES` cycles. When busy drops, the addressed cell holds the data and `prog_done` is high for exactly one cycle.
- R6: While busy, window reads return 00h and window writes are dropped.
- R7: While busy, `ctl_rdata` reads 08h (busy is bit3) and control-register writes are ignored.
- R8: Bits 4, 5 and 7 of the control register always read 0, even when written as 1.
- R9: In row mode (bit0=1, bit1=1), window writes are only latched. The row is fixed by the first latched write: bank plus address[5:3]. Writes to any other row are ignored, and nothing reaches the array before a start.
- R10: A control write with bits 0, 1 and 2 set and bit6 clear starts programming if at least one byte is latched. Only the latched bytes are programmed, in one busy period of `PROG_CYCLES` cycles. Afterwards the latches are empty and bit2 reads 0. A start with no latched bytes does nothing.
- R11: `stop_req` blocks window reads in the cycle it is high and leaves the control register unchanged.
- R12: Each bank is a separate page. A write in one bank leaves the same address in the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_req | input | 1 | Low-power request; disables the array while high |
| bank_valid | input | 1 | A bank is selected |
| bank_idx | input | 1 | Selected bank number |
| win_rd | input | 1 | Window read strobe |
| win_wr | input | 1 | Window write strobe |
| win_addr | input | 6 | Window address (row = [5:3], byte = [2:0]) |
| win_wdata | input | 8 | Window write data |
| win_rdata | output | 8 | Window read data, 00h when blocked |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_wdata | input | 8 | Control-register write data |
| ctl_rdata | output | 8 | Control/status register read value |
| prog_done | output | 1 | One-cycle pulse when a programming cycle ends |

## Verification
The state most likely to go wrong is the busy counter or the row latch. A counter that is off by one moves the `prog_done` pulse and the return from 08h to the normal control value by one cycle, and the bench samples exactly at that boundary. A latch that keeps stale valid bits or accepts a second row shows up as wrong bytes when the window is read back after the next busy period ends, which is about twenty cycles later. A control register that a write reaches while busy shows the wrong value on the first read after busy drops.

// File: rtl/nvm_page_ctrl.sv
module nvm_page_ctrl #(
  parameter int NUM_BANKS   = 2,
  parameter int PROG_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       bank_valid,
  input  logic       bank_idx,
  input  logic       win_rd,
  input  logic       win_wr,
  input  logic [5:0] win_addr,
  input  logic [7:0] win_wdata,
  output logic [7:0] win_rdata,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  output logic       prog_done
);
  localparam int PAGE      = 64;
  localparam int ROW_BYTES = 8;
  localparam int DEPTH     = NUM_BANKS * PAGE;
  localparam int IDX_W     = $clog2(DEPTH);
  localparam int CNT_W     = $clog2(PROG_CYCLES + 1);

  logic pe_q, row_q, off_q, busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0][7:0] mem_q;
  logic lat_bank_q;
  logic [2:0] lat_row_q;
  logic [ROW_BYTES-1:0] lat_vld_q;
  logic [ROW_BYTES-1:0][7:0] lat_dat_q;

  wire bank_ok  = bank_valid && (NUM_BANKS > 1 || !bank_idx);
  wire active   = bank_ok && !off_q && !stop_req && !busy_q;
  wire [IDX_W-1:0] acc_idx = IDX_W'({bank_idx, win_addr});
  wire wr_ok    = active && win_wr && pe_q;
  wire row_hit  = (lat_vld_q == '0) ||
                  (lat_row_q == win_addr[5:3] && lat_bank_q == bank_idx);
  wire byte_go  = wr_ok && !row_q;
  wire row_ld   = wr_ok && row_q && row_hit;
  wire ctl_take = ctl_wr && !busy_q;
  wire row_go   = ctl_take && (ctl_wdata[2:0] == 3'b111) && !ctl_wdata[6] &&
                  !stop_req && (lat_vld_q != '0);
  wire commit   = busy_q && (cnt_q == '0);

  assign win_rdata = (active && win_rd) ? mem_q[acc_idx] : 8'h00;
  assign ctl_rdata = busy_q ? 8'h08 : {1'b0, off_q, 4'b0000, row_q, pe_q};
  assign prog_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pe_q  <= 1'b0;
      row_q <= 1'b0;
      off_q <= 1'b1;
    end else if (ctl_take) begin
      pe_q  <= ctl_wdata[0];
      row_q <= ctl_wdata[1];
      off_q <= ctl_wdata[6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      cnt_q      <= '0;
      lat_vld_q  <= '0;
      lat_row_q  <= '0;
      lat_bank_q <= 1'b0;
      lat_dat_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (commit) begin
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
          lat_vld_q <= '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (byte_go) begin
        lat_vld_q                  <= ROW_BYTES'(1) << win_addr[2:0];
        lat_dat_q[win_addr[2:0]]   <= win_wdata;
        lat_row_q                  <= win_addr[5:3];
        lat_bank_q                 <= bank_idx;
        busy_q                     <= 1'b1;
        cnt_q                      <= CNT_W'(PROG_CYCLES - 1);
      end else if (row_go) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(PROG_CYCLES - 1);
      end else if (row_ld) begin
        lat_vld_q[win_addr[2:0]] <= 1'b1;
        lat_dat_q[win_addr[2:0]] <= win_wdata;
        lat_row_q                <= win_addr[5:3];
        lat_bank_q               <= bank_idx;
      end else if (ctl_take && !ctl_wdata[1]) begin
        lat_vld_q <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '1;
    end else if (commit) begin
      for (int i = 0; i < ROW_BYTES; i++) begin
        if (lat_vld_q[i])
          mem_q[IDX_W'({lat_bank_q, lat_row_q, 3'(i)})] <= lat_dat_q[i];
      end
    end
  end

  p_ctl_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable({pe_q, row_q, off_q}));

  p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(mem_q));

  p_done_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> (!busy_q && $past(busy_q)));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !prog_done);

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[7] == 1'b0) && (ctl_rdata[5:4] == 2'b00));

  p_blind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q || stop_req || !bank_valid || busy_q) |-> (win_rdata == 8'h00));

  p_one_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_vld_q != '0 && !busy_q) |=>
      (lat_vld_q == '0 || $stable({lat_row_q, lat_bank_q})));
endmodule

// File: tb/nvm_page_ctrl_bench.sv
module nvm_page_ctrl_bench;
  localparam int P = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_req = 1'b0, bank_valid = 1'b1, bank_idx = 1'b0;
  logic win_rd = 1'b0, win_wr = 1'b0, ctl_wr = 1'b0;
  logic [5:0] win_addr = '0;
  logic [7:0] win_wdata = '0, ctl_wdata = '0;
  logic [7:0] win_rdata, ctl_rdata;
  logic prog_done;

  nvm_page_ctrl #(.NUM_BANKS(2), .PROG_CYCLES(P)) u_nvm_page_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .bank_valid(bank_valid),
    .bank_idx(bank_idx), .win_rd(win_rd), .win_wr(win_wr), .win_addr(win_addr),
    .win_wdata(win_wdata), .win_rdata(win_rdata), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .prog_done(prog_done));

  always #10 clk = ~clk;

  typedef struct {int port; logic [7:0] exp; string req;} item_t;
  item_t sb[$];
  item_t it;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] act;

  initial forever begin
    @(negedge clk);
    while (sb.size() != 0) begin
      it = sb.pop_front();
      case (it.port)
        0: act = win_rdata;
        1: act = ctl_rdata;
        default: act = {7'b0, prog_done};
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: port %0d got %02h expected %02h", it.req, it.port, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
    win_rd = 1'b0; win_wr = 1'b0; ctl_wr = 1'b0;
  endtask
  task automatic push(int p, logic [7:0] e, string r);
    item_t x;
    x.port = p; x.exp = e; x.req = r;
    sb.push_back(x);
  endtask
  task automatic wwr(logic [5:0] a, logic [7:0] d);
    step(); win_wr = 1'b1; win_addr = a; win_wdata = d;
  endtask
  task automatic cwr(logic [7:0] v);
    step(); ctl_wr = 1'b1; ctl_wdata = v;
  endtask
  task automatic rd(logic [5:0] a, logic [7:0] e, string r);
    step(); win_rd = 1'b1; win_addr = a; push(0, e, r);
  endtask
  task automatic wait_prog(string r);
    step(); push(1, 8'h08, r);
    repeat (P - 1) step();
    step(); push(2, 8'h01, r);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    push(1, 8'h40, "R1"); push(2, 8'h00, "R1");
    rd(6'h05, 8'h00, "R2");
    cwr(8'h00);
    rd(6'h05, 8'hFF, "R1");
    rd(6'h3F, 8'hFF, "R3");
    // R4: writes without programming enable
    wwr(6'h05, 8'hA5);
    step(); push(1, 8'h00, "R4");
    rd(6'h05, 8'hFF, "R4");
    // R8: reserved bits masked
    cwr(8'hB1);
    step(); push(1, 8'h01, "R8");
    // R5/R6/R7: byte programming and busy lockouts
    wwr(6'h05, 8'hA5);
    rd(6'h05, 8'h00, "R6"); push(1, 8'h08, "R7");
    wwr(6'h06, 8'h11);
    cwr(8'h40);
    repeat (P - 4) step();
    step(); push(1, 8'h08, "R5"); push(2, 8'h00, "R5");
    step(); push(2, 8'h01, "R5"); push(1, 8'h01, "R7");
    rd(6'h05, 8'hA5, "R5"); push(2, 8'h00, "R5");
    rd(6'h06, 8'hFF, "R6");
    // R9/R10: row mode
    cwr(8'h03);
    step(); push(1, 8'h03, "R9");
    wwr(6'h10, 8'h21); wwr(6'h13, 8'h24); wwr(6'h17, 8'h28); wwr(6'h20, 8'h99);
    rd(6'h10, 8'hFF, "R9"); push(1, 8'h03, "R9");
    cwr(8'h07);
    wait_prog("R10"); push(1, 8'h03, "R10");
    rd(6'h10, 8'h21, "R10"); rd(6'h11, 8'hFF, "R10"); rd(6'h13, 8'h24, "R10");
    rd(6'h17, 8'h28, "R10"); rd(6'h20, 8'hFF, "R9");
    cwr(8'h07);
    step(); push(1, 8'h03, "R10");
    step(); push(2, 8'h00, "R10");
    wwr(6'h28, 8'h55);
    cwr(8'h07);
    wait_prog("R10");
    rd(6'h28, 8'h55, "R10"); rd(6'h10, 8'h21, "R10");
    // R12: second bank
    cwr(8'h01);
    step(); bank_idx = 1'b1;
    rd(6'h10, 8'hFF, "R12");
    wwr(6'h10, 8'h77);
    wait_prog("R12");
    rd(6'h10, 8'h77, "R12");
    step(); bank_idx = 1'b0;
    rd(6'h10, 8'h21, "R12");
    // R11: stop request
    step(); stop_req = 1'b1;
    rd(6'h10, 8'h00, "R11"); push(1, 8'h01, "R11");
    step(); stop_req = 1'b0;
    rd(6'h10, 8'h21, "R11");
    // R2: no bank, then array off
    step(); bank_valid = 1'b0;
    rd(6'h10, 8'h00, "R2");
    step(); bank_valid = 1'b1;
    cwr(8'h41);
    step(); push(1, 8'h41, "R2");
    rd(6'h10, 8'h00, "R2");
    wwr(6'h10, 8'h33);
    step(); push(1, 8'h41, "R2");
    cwr(8'h01);
    rd(6'h10, 8'h21, "R2");
    step(); step();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule